// File: doc/BRIEF.md
# Pattern Fill Source Address Generator

This block produces the video memory read address for the source side of a 2D block transfer that fills an area from an 8×8 pattern, or from a stream of monochrome bits. It holds a byte counter inside the current pattern row and a 3-bit pattern row counter. It drives a byte address, a one-hot pixel bit select for monochrome sources, and a flag that tells the colour path to use the foreground colour.

The transfer engine pulses `start` once before a transfer. After that it pulses `step` once per destination byte and `row_adv` once per destination line. The address always reflects the current counters. It is combinational from the counter registers and the configuration inputs, so the engine can issue the memory read in the same cycle in which it samples the address. The final address is always ANDed with a configurable video memory size mask.

Top module: `pattern_src_agen`

## Requirements
- R1: After reset, both counters and the stream source register are zero. With `fill_mode`=0 and `depth`=0 the address is `base_addr` with its low 3 bits cleared. With `fill_mode`=3 the address is 0.
- R2: Each `step` pulse advances the byte counter by one. After reaching its last value it returns to 0. The wrap happens at 8, 16, 24 or 32 bytes for `depth` codes 0, 1, 2 and 3 (1, 2, 3 and 4 bytes per pixel).
- R3: Each `row_adv` pulse advances the row counter by one, wrapping from 7 to 0, and clears the byte counter. When `row_adv` and `step` arrive in the same cycle, `step` is ignored.
- R4: `start` clears both counters and loads the stream source register with `base_addr`. It overrides `step` and `row_adv` in the same cycle.
- R5: Colour pattern (`fill_mode`=0) at depth code 0 gives (base AND ~7) + row×8 + (byte AND 7). Code 1 gives (base AND ~15) + row×16 + (byte AND 15). Code 2 gives (base AND ~31) + row×32 + (byte mod 24). Code 3 gives (base AND ~31) + row×32 + (byte AND 31). In this mode `bit_mask` is 0.
- R6: Monochrome pattern (`fill_mode`=1) gives the address (base AND ~7) OR row. `bit_mask` is 0x80 shifted right by the pixel index, which is the byte counter divided by the bytes per pixel.
- R7: Solid fill (`fill_mode`=2) drives `force_fg`=1 and `bit_mask`=0, and the address is the masked base. In every other mode `force_fg` is 0.
- R8: Monochrome stream (`fill_mode`=3) uses the stream source register as the address and the same `bit_mask` rule as R6. The register increments by one each time a `step` wraps the byte counter.
- R9: In monochrome stream mode, a `row_adv` while the byte counter is non-zero increments the stream source register by one. A `row_adv` while the counter is zero leaves the register unchanged.
- R10: Every address bit that is clear in `vram_mask` is 0 on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin transfer: clear counters, load stream source |
| step | input | 1 | Advance one destination byte |
| row_adv | input | 1 | Advance one destination line |
| fill_mode | input | 2 | 0 colour pattern, 1 mono pattern, 2 solid, 3 mono stream |
| depth | input | 2 | 0/1/2/3 for 1/2/3/4 bytes per pixel |
| base_addr | input | ADDR_W | Pattern or stream base address |
| vram_mask | input | ADDR_W | Video memory size mask |
| rd_addr | output | ADDR_W | Source byte address |
| bit_mask | output | 8 | One-hot pixel bit select for mono sources |
| force_fg | output | 1 | Select foreground colour (solid fill) |

## Verification
The bench builds the block with `ADDR_W`=16, which is narrower than the default. This lets a base address near the top of the space, combined with a mask of 0x03FF, show that high bits are dropped after the row and column offsets are added. All four depth codes are run through more than one full wrap of the byte counter. A run of nine row advances reaches the 7-to-0 wrap. The stream mode is run long enough to cross several byte boundaries, then given partial-byte line advances.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    typedef enum logic [1:0] {
        FILL_COLOR  = 2'd0,
        FILL_MONO   = 2'd1,
        FILL_SOLID  = 2'd2,
        FILL_STREAM = 2'd3
    } fill_mode_e;

    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_16 = 2'd1,
        DEPTH_24 = 2'd2,
        DEPTH_32 = 2'd3
    } depth_e;

    localparam int PAT_ROWS = 8;
    localparam int ROW_W    = $clog2(PAT_ROWS);
    localparam int MAX_ROW  = 32;
    localparam int BCNT_W   = $clog2(MAX_ROW);

    typedef struct packed {
        logic [BCNT_W-1:0] bcnt;
        logic [ROW_W-1:0]  row;
    } pat_pos_t;

    // last byte index of a pattern row for a given depth
    function automatic logic [BCNT_W-1:0] row_last(input depth_e d);
        case (d)
            DEPTH_8:  row_last = BCNT_W'(7);
            DEPTH_16: row_last = BCNT_W'(15);
            DEPTH_24: row_last = BCNT_W'(23);
            default:  row_last = BCNT_W'(31);
        endcase
    endfunction

    // pixel index within the row = byte counter / bytes per pixel
    function automatic logic [2:0] pix_index(input depth_e d, input logic [BCNT_W-1:0] b);
        case (d)
            DEPTH_8:  pix_index = b[2:0];
            DEPTH_16: pix_index = b[3:1];
            DEPTH_24: pix_index = 3'(b / BCNT_W'(3));
            default:  pix_index = b[4:2];
        endcase
    endfunction

endpackage

// File: rtl/pfa_pos_ctr.sv
module pfa_pos_ctr
    import pfa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     step,
    input  logic     row_adv,
    input  depth_e   depth,
    output pat_pos_t pos,
    output logic     byte_wrap,
    output logic     row_partial
);

    pat_pos_t          pos_q;
    logic [BCNT_W-1:0] last;

    assign last        = row_last(depth);
    assign byte_wrap   = step && !start && !row_adv && (pos_q.bcnt == last);
    assign row_partial = row_adv && !start && (pos_q.bcnt != '0);
    assign pos         = pos_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            pos_q <= '0;
        end else if (row_adv) begin
            pos_q.row  <= pos_q.row + ROW_W'(1);
            pos_q.bcnt <= '0;
        end else if (step) begin
            if (pos_q.bcnt == last)
                pos_q.bcnt <= '0;
            else
                pos_q.bcnt <= pos_q.bcnt + BCNT_W'(1);
        end
    end

endmodule

// File: rtl/pfa_stream_src.sv
module pfa_stream_src #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              adv,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] src_addr
);

    always_ff @(posedge clk) begin
        if (rst)
            src_addr <= '0;
        else if (start)
            src_addr <= base_addr;
        else if (adv)
            src_addr <= src_addr + ADDR_W'(1);
    end

endmodule

// File: rtl/pfa_addr_map.sv
module pfa_addr_map
    import pfa_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  fill_mode_e        mode,
    input  depth_e            depth,
    input  pat_pos_t          pos,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] vram_mask,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        bit_mask,
    output logic              force_fg
);

    logic [ADDR_W-1:0] aligned, row_off, col_off, color_addr, mono_addr, raw;
    logic [2:0]        pix;

    always_comb begin
        case (depth)
            DEPTH_8: begin
                aligned = base_addr & ~ADDR_W'(7);
                row_off = ADDR_W'({pos.row, 3'b000});
                col_off = ADDR_W'(pos.bcnt & BCNT_W'(7));
            end
            DEPTH_16: begin
                aligned = base_addr & ~ADDR_W'(15);
                row_off = ADDR_W'({pos.row, 4'b0000});
                col_off = ADDR_W'(pos.bcnt & BCNT_W'(15));
            end
            DEPTH_24: begin
                aligned = base_addr & ~ADDR_W'(31);
                row_off = ADDR_W'({pos.row, 5'b00000});
                col_off = ADDR_W'(pos.bcnt % BCNT_W'(24));
            end
            default: begin
                aligned = base_addr & ~ADDR_W'(31);
                row_off = ADDR_W'({pos.row, 5'b00000});
                col_off = ADDR_W'(pos.bcnt);
            end
        endcase
    end

    assign color_addr = aligned + row_off + col_off;
    assign mono_addr  = (base_addr & ~ADDR_W'(7)) | ADDR_W'(pos.row);
    assign pix        = pix_index(depth, pos.bcnt);

    always_comb begin
        raw      = base_addr;
        bit_mask = 8'h00;
        force_fg = 1'b0;
        case (mode)
            FILL_COLOR:  raw = color_addr;
            FILL_MONO: begin
                raw      = mono_addr;
                bit_mask = 8'h80 >> pix;
            end
            FILL_SOLID:  force_fg = 1'b1;
            default: begin
                raw      = src_addr;
                bit_mask = 8'h80 >> pix;
            end
        endcase
    end

    assign rd_addr = raw & vram_mask;

endmodule

// File: rtl/pattern_src_agen.sv
module pattern_src_agen
    import pfa_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic              row_adv,
    input  logic [1:0]        fill_mode,
    input  logic [1:0]        depth,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] vram_mask,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        bit_mask,
    output logic              force_fg
);

    fill_mode_e        mode_e;
    depth_e            depth_e_s;
    pat_pos_t          pos;
    logic              byte_wrap, row_partial, src_adv;
    logic [ADDR_W-1:0] src_addr;
    logic [BCNT_W-1:0] cur_bcnt;
    logic [ROW_W-1:0]  cur_row;

    assign mode_e    = fill_mode_e'(fill_mode);
    assign depth_e_s = depth_e'(depth);
    assign cur_bcnt  = pos.bcnt;
    assign cur_row   = pos.row;
    assign src_adv   = (mode_e == FILL_STREAM) && (byte_wrap || row_partial);

    pfa_pos_ctr u_pos (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .step        (step),
        .row_adv     (row_adv),
        .depth       (depth_e_s),
        .pos         (pos),
        .byte_wrap   (byte_wrap),
        .row_partial (row_partial)
    );

    pfa_stream_src #(.ADDR_W(ADDR_W)) u_src (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .adv       (src_adv),
        .base_addr (base_addr),
        .src_addr  (src_addr)
    );

    pfa_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .mode      (mode_e),
        .depth     (depth_e_s),
        .pos       (pos),
        .base_addr (base_addr),
        .src_addr  (src_addr),
        .vram_mask (vram_mask),
        .rd_addr   (rd_addr),
        .bit_mask  (bit_mask),
        .force_fg  (force_fg)
    );

endmodule

// File: rtl/pattern_src_agen_chk.sv
module pattern_src_agen_chk
    import pfa_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              step,
    input logic              row_adv,
    input logic [1:0]        fill_mode,
    input logic [1:0]        depth,
    input logic [ADDR_W-1:0] vram_mask,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        bit_mask,
    input logic              force_fg,
    input logic [BCNT_W-1:0] cur_bcnt,
    input logic [ROW_W-1:0]  cur_row
);

    AST_BYTE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !start && !row_adv && cur_bcnt == row_last(depth_e'(depth))) |=> (cur_bcnt == '0)); // R2

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (row_adv && !start && cur_row == ROW_W'(PAT_ROWS - 1)) |=> (cur_row == '0 && cur_bcnt == '0)); // R3

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> (cur_bcnt == '0 && cur_row == '0)); // R4

    AST_MONO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        fill_mode[0] |-> ($countones(bit_mask) == 1)); // R6

    AST_SOLID_FG: assert property (@(posedge clk) disable iff (rst)
        (fill_mode == 2'd2) |-> (force_fg && bit_mask == 8'h00)); // R7

    AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((rd_addr & ~vram_mask) == '0)); // R10

endmodule

bind pattern_src_agen pattern_src_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .step      (step),
    .row_adv   (row_adv),
    .fill_mode (fill_mode),
    .depth     (depth),
    .vram_mask (vram_mask),
    .rd_addr   (rd_addr),
    .bit_mask  (bit_mask),
    .force_fg  (force_fg),
    .cur_bcnt  (cur_bcnt),
    .cur_row   (cur_row)
);

// File: tb/pattern_src_agen_bench.sv
module pattern_src_agen_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, step = 1'b0, row_adv = 1'b0;
    logic [1:0]    fill_mode;
    logic [1:0]    depth;
    logic [AW-1:0] base_addr, vram_mask;
    logic [AW-1:0] rd_addr;
    logic [7:0]    bit_mask;
    logic          force_fg;

    int n_checks = 0;
    int n_err    = 0;
    int m_mode = 0, m_depth = 0, m_base = 0, m_mask = 16'hFFFF;
    int m_b = 0, m_row = 0, m_src = 0;

    assign fill_mode = 2'(m_mode);
    assign depth     = 2'(m_depth);
    assign base_addr = AW'(m_base);
    assign vram_mask = AW'(m_mask);

    always #2.5 clk = ~clk;

    pattern_src_agen #(.ADDR_W(AW)) u_pattern_src_agen (
        .clk(clk), .rst(rst), .start(start), .step(step), .row_adv(row_adv),
        .fill_mode(fill_mode), .depth(depth), .base_addr(base_addr),
        .vram_mask(vram_mask), .rd_addr(rd_addr), .bit_mask(bit_mask),
        .force_fg(force_fg)
    );

    function automatic int xmax(input int d);
        return (d + 1) * 8;
    endfunction

    function int exp_addr();
        int a;
        case (m_mode)
            0: begin
                case (m_depth)
                    0: a = (m_base & ~7)  + m_row * 8  + (m_b & 7);
                    1: a = (m_base & ~15) + m_row * 16 + (m_b & 15);
                    2: a = (m_base & ~31) + m_row * 32 + (m_b % 24);
                    default: a = (m_base & ~31) + m_row * 32 + (m_b & 31);
                endcase
            end
            1: a = (m_base & ~7) | m_row;
            2: a = m_base;
            default: a = m_src;
        endcase
        return a & m_mask;
    endfunction

    function int exp_bits();
        if (m_mode == 1 || m_mode == 3)
            return (8'h80 >> (m_b / (m_depth + 1)));
        return 0;
    endfunction

    task automatic check_out(input string rq);
        int ea, eb, ef;
        ea = exp_addr();
        eb = exp_bits();
        ef = (m_mode == 2) ? 1 : 0;
        n_checks++;
        if (rd_addr !== AW'(ea) || bit_mask !== 8'(eb) || force_fg !== 1'(ef)) begin
            n_err++;
            $display("FAIL %s addr/bits/fg got %h/%h/%0d exp %h/%h/%0d",
                     rq, rd_addr, bit_mask, force_fg, AW'(ea), 8'(eb), ef);
        end
    endtask

    task automatic pulse(input logic st, input logic sp, input logic ra);
        @(negedge clk);
        start = st; step = sp; row_adv = ra;
        @(negedge clk);
        start = 1'b0; step = 1'b0; row_adv = 1'b0;
        if (st) begin
            m_b = 0; m_row = 0; m_src = m_base & 16'hFFFF;
        end else if (ra) begin
            if (m_mode == 3 && m_b != 0) m_src = (m_src + 1) & 16'hFFFF;
            m_row = (m_row + 1) & 7;
            m_b = 0;
        end else if (sp) begin
            if (m_b == xmax(m_depth) - 1) begin
                m_b = 0;
                if (m_mode == 3) m_src = (m_src + 1) & 16'hFFFF;
            end else m_b++;
        end
    endtask

    task automatic set_cfg(input int mode, input int d, input int base, input int msk);
        @(negedge clk);
        m_mode = mode; m_depth = d; m_base = base; m_mask = msk;
    endtask

    task automatic t_reset();
        set_cfg(0, 0, 16'h1234, 16'hFFFF);
        @(negedge clk);
        check_out("R1 colour after reset");
        set_cfg(3, 0, 16'h1234, 16'hFFFF);
        @(negedge clk);
        check_out("R1 stream after reset");
    endtask

    task automatic t_color(input int d);
        set_cfg(0, d, 16'hA5B7, 16'hFFFF);
        pulse(1, 0, 0);
        check_out("R5 colour start");
        for (int i = 0; i < xmax(d) + 3; i++) begin
            pulse(0, 1, 0);
            check_out("R2 R5 colour step");
        end
        pulse(0, 0, 1);
        check_out("R5 colour row");
        for (int i = 0; i < 5; i++) begin
            pulse(0, 1, 0);
            check_out("R5 colour row step");
        end
    endtask

    task automatic t_rows();
        set_cfg(1, 0, 16'h3C45, 16'hFFFF);
        pulse(1, 0, 0);
        for (int i = 0; i < 9; i++) begin
            pulse(0, 0, 1);
            check_out("R3 row wrap");
        end
        for (int i = 0; i < 3; i++) pulse(0, 1, 0);
        check_out("R3 pre-collision");
        pulse(0, 1, 1);
        check_out("R3 row beats step");
    endtask

    task automatic t_mono(input int d);
        set_cfg(1, d, 16'h0F0F, 16'hFFFF);
        pulse(1, 0, 0);
        pulse(0, 0, 1);
        pulse(0, 0, 1);
        for (int i = 0; i < xmax(d) + 1; i++) begin
            pulse(0, 1, 0);
            check_out("R6 mono pattern");
        end
    endtask

    task automatic t_solid();
        set_cfg(2, 1, 16'h4321, 16'hFFFF);
        pulse(1, 0, 0);
        for (int i = 0; i < 4; i++) begin
            pulse(0, 1, 0);
            check_out("R7 solid fill");
        end
        set_cfg(0, 1, 16'h4321, 16'hFFFF);
        @(negedge clk);
        check_out("R7 fg clear outside solid");
    endtask

    task automatic t_stream();
        set_cfg(3, 1, 16'h0200, 16'hFFFF);
        pulse(1, 0, 0);
        check_out("R8 stream start");
        for (int i = 0; i < 40; i++) begin
            pulse(0, 1, 0);
            check_out("R8 stream step");
        end
        pulse(0, 0, 1);
        check_out("R9 partial row advance");
        pulse(0, 0, 1);
        check_out("R9 row advance on byte boundary");
        set_cfg(3, 2, 16'h0200, 16'hFFFF);
        for (int i = 0; i < 26; i++) begin
            pulse(0, 1, 0);
            check_out("R8 stream 24bpp");
        end
    endtask

    task automatic t_start();
        set_cfg(3, 0, 16'h0100, 16'hFFFF);
        pulse(1, 0, 0);
        for (int i = 0; i < 11; i++) pulse(0, 1, 0);
        pulse(0, 0, 1);
        m_base = 16'h0777;
        pulse(1, 1, 1);
        check_out("R4 start reloads stream");
        set_cfg(0, 3, 16'h0777, 16'hFFFF);
        @(negedge clk);
        check_out("R4 start cleared counters");
    endtask

    task automatic t_mask();
        set_cfg(0, 3, 16'hFFF3, 16'h03FF);
        pulse(1, 0, 0);
        for (int i = 0; i < 3; i++) pulse(0, 0, 1);
        for (int i = 0; i < 6; i++) begin
            pulse(0, 1, 0);
            check_out("R10 masked colour");
        end
        set_cfg(3, 0, 16'hFFFF, 16'h03FF);
        pulse(1, 0, 0);
        for (int i = 0; i < 10; i++) begin
            pulse(0, 1, 0);
            check_out("R10 masked stream");
        end
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_err++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        for (int d = 0; d < 4; d++) t_color(d);
        t_rows();
        for (int d = 0; d < 4; d++) t_mono(d);
        t_solid();
        t_stream();
        t_start();
        t_mask();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule